// File: doc/BRIEF.md
# Bit-Serial Adder with Shifting Accumulator

The block adds two unsigned operands with a single full adder that is reused once per clock. A load strobe copies both operand buses into two shift registers. A start request then runs an addition. In each cycle the two least significant operand bits and the stored carry form one sum bit. That sum bit is shifted into a result register from the top, so after the last shift the register holds the whole sum. The carry flip-flop then holds the carry out of the top bit.

A parameter selects how the sum bit reaches the result register. In the Mealy variant it goes straight from the full adder. In the Moore variant it first passes through one flip-flop, so the addition needs one more shift cycle. A busy flag covers the addition. A one-cycle done pulse marks the point at which the result and the carry-out are valid. Both stay valid until the next clear or the next completion.

Top module: `ser_acc_adder`

## Requirements
- R1: When rst_n is low or clr is high at a clock edge, busy, done, sum and cout are 0 after that edge and both operand registers are emptied. Clear overrides load and start, and it aborts a running addition with no done pulse.
- R2: A load while idle captures opa and opb and zeroes the carry. It does not change sum.
- R3: A start while idle with load low begins an addition. busy is high from the next cycle for exactly WIDTH cycles in the Mealy variant (MOORE = 0).
- R4: done is high for exactly one cycle. That cycle immediately follows the last busy cycle, and busy is low in it.
- R5: When done is high, sum equals (A + B + Cin) mod 2^WIDTH and cout equals bit WIDTH of that total. A and B are the operand register contents and Cin is the stored carry. Both outputs hold until the next clear or the next completion.
- R6: load and start have no effect while busy is high. The running addition ends normally, and its result still comes from the operands it started with.
- R7: If load and start are both high in an idle cycle, load wins and start is ignored. busy stays low.
- R8: Operands leave least significant bit first, with zeros shifted in behind them. A second start with no new load therefore adds zero to zero plus the previous carry: sum equals the previous cout and cout becomes 0.
- R9: With MOORE = 1 the results follow R5, but busy lasts WIDTH + 1 cycles, so done comes one cycle later than in the Mealy variant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of all state |
| load | input | 1 | Capture opa and opb when idle |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| start | input | 1 | Begin an addition when idle |
| busy | output | 1 | Addition in progress |
| done | output | 1 | One-cycle completion pulse |
| sum | output | WIDTH | Accumulated result |
| cout | output | 1 | Final carry-out |

## Verification
A wrong carry or a misaligned sum bit does not show at the ports until the addition ends. It then appears as a wrong sum or cout in the done cycle, at most WIDTH + 1 cycles after start. A wrong shift count shows earlier, as busy falling in the wrong cycle. The reference model follows both variants cycle by cycle with the same stimulus. It keeps the leftover operand and carry state, so repeated starts without a new load also expose fill and carry errors.

// File: rtl/sa_pkg.sv
// Shared types and helpers for the bit-serial adder.
// Assumes nothing beyond plain two-state arithmetic on single bits.
package sa_pkg;

    // Sequencer phase
    typedef enum logic {
        SA_IDLE = 1'b0,
        SA_RUN  = 1'b1
    } sa_phase_e;

    // Carry of a one-bit full adder (majority of three)
    function automatic logic sa_majority(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/sa_operand_shreg.sv
// Operand shift register: parallel load, shifts right one bit per step
// with zero fill, presents its least significant bit.
// Assumes clr and load are already qualified by the caller.
module sa_operand_shreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] din,
    output logic             lsb
);

    logic [WIDTH-1:0] q;

    // Clear beats load, load beats shift
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end else if (shift) begin
            q <= {1'b0, q[WIDTH-1:1]};
        end
    end

    assign lsb = q[0];

    AST_OPND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load && !shift) |=> $stable(q)); // R6

    AST_OPND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0)); // R1

endmodule

// File: rtl/sa_bit_adder.sv
// One-bit full adder with carry flip-flop. With MOORE set, the sum bit
// is registered on each step before leaving the module.
// Assumes step is only high while operand bits are valid.
module sa_bit_adder #(
    parameter bit MOORE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    input  logic step,
    input  logic a,
    input  logic b,
    output logic sum_bit,
    output logic carry
);

    logic carry_q;
    logic s_comb;
    logic c_next;

    // Combinational full adder
    always_comb begin
        s_comb = a ^ b ^ carry_q;
        c_next = sa_pkg::sa_majority(a, b, carry_q);
    end

    // Carry flip-flop: cleared by clear or load, advanced by step
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            carry_q <= 1'b0;
        end else if (load) begin
            carry_q <= 1'b0;
        end else if (step) begin
            carry_q <= c_next;
        end
    end

    assign carry = carry_q;

    generate
        if (MOORE) begin : g_moore
            logic sbit_q;
            // Extra sum flip-flop for the registered variant
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    sbit_q <= 1'b0;
                end else if (step) begin
                    sbit_q <= s_comb;
                end
            end
            assign sum_bit = sbit_q;
        end else begin : g_mealy
            assign sum_bit = s_comb;
        end
    endgenerate

    AST_CARRY_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> !carry_q); // R2

    AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load && !step) |=> $stable(carry_q)); // R5

endmodule

// File: rtl/sa_result_shreg.sv
// Result accumulator: each step shifts the incoming sum bit in at the
// top, so the first bit ends in the least significant position.
// Assumes exactly as many steps per addition as the sequencer issues.
module sa_result_shreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift,
    input  logic             bit_in,
    output logic [WIDTH-1:0] q
);

    // Clear or shift the accumulator
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (shift) begin
            q <= {bit_in, q[WIDTH-1:1]};
        end
    end

    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !shift) |=> $stable(q)); // R5

endmodule

// File: rtl/sa_sequencer.sv
// Sequencer: accepts load and start only when idle, runs TOTAL shift
// cycles, drives operand and result steps and the done pulse.
// Assumes operand steps stop after WIDTH cycles; the extra cycle of the
// registered variant only moves the result register.
module sa_sequencer #(
    parameter int WIDTH = 8,
    parameter bit MOORE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    input  logic start,
    output logic load_en,
    output logic op_step,
    output logic res_step,
    output logic busy,
    output logic done
);

    import sa_pkg::*;

    localparam int TOTAL = WIDTH + (MOORE ? 1 : 0);
    localparam int CW    = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] LAST   = CW'(TOTAL - 1);
    localparam logic [CW-1:0] OP_END = CW'(WIDTH);

    sa_phase_e     phase;
    logic [CW-1:0] cnt;
    logic          done_q;
    logic          go;

    always_comb begin
        busy     = (phase == SA_RUN);
        load_en  = load && !busy;
        go       = start && !load && !busy;
        op_step  = busy && (cnt < OP_END);
        res_step = busy;
    end

    // Phase, shift counter and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase  <= SA_IDLE;
            cnt    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (busy) begin
                if (cnt == LAST) begin
                    phase  <= SA_IDLE;
                    cnt    <= '0;
                    done_q <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (go) begin
                phase <= SA_RUN;
                cnt   <= '0;
            end
        end
    end

    assign done = done_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R4

    AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start && !load && !clr)); // R3

    AST_LOAD_START_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && load && !clr) |=> !busy); // R7

endmodule

// File: rtl/ser_acc_adder.sv
// Top of the bit-serial adder: two operand shift registers, a shared
// full adder with carry flip-flop and a shifting result accumulator,
// driven by the sequencer. MOORE selects the registered sum path.
// Assumes operands are unsigned and at most 16 bits wide.
module ser_acc_adder #(
    parameter int WIDTH = 8,
    parameter bit MOORE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    logic load_en;
    logic op_step;
    logic res_step;
    logic a_bit;
    logic b_bit;
    logic s_bit;

    sa_sequencer #(.WIDTH(WIDTH), .MOORE(MOORE)) u_seq (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .start(start),
        .load_en(load_en), .op_step(op_step), .res_step(res_step),
        .busy(busy), .done(done)
    );

    sa_operand_shreg #(.WIDTH(WIDTH)) u_opa (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load(load_en),
        .shift(op_step), .din(opa), .lsb(a_bit)
    );

    sa_operand_shreg #(.WIDTH(WIDTH)) u_opb (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load(load_en),
        .shift(op_step), .din(opb), .lsb(b_bit)
    );

    sa_bit_adder #(.MOORE(MOORE)) u_fa (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load(load_en),
        .step(op_step), .a(a_bit), .b(b_bit),
        .sum_bit(s_bit), .carry(cout)
    );

    sa_result_shreg #(.WIDTH(WIDTH)) u_res (
        .clk(clk), .rst_n(rst_n), .clr(clr), .shift(res_step),
        .bit_in(s_bit), .q(sum)
    );

    AST_RUN_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clr) |=> (busy || done)); // R6

    AST_CLEAR_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!busy && !done && sum == '0 && !cout)); // R1

endmodule

// File: tb/ser_acc_adder_tb_top.sv
module ser_acc_adder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic load = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;

    logic [1:0]   d_busy;
    logic [1:0]   d_done;
    logic [1:0]   d_cout;
    logic [W-1:0] d_sum [2];

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_acc_adder #(.WIDTH(W), .MOORE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .opa(opa), .opb(opb),
        .start(start), .busy(d_busy[0]), .done(d_done[0]), .sum(d_sum[0]),
        .cout(d_cout[0])
    );

    ser_acc_adder #(.WIDTH(W), .MOORE(1'b1)) dut_m_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .opa(opa), .opb(opb),
        .start(start), .busy(d_busy[1]), .done(d_done[1]), .sum(d_sum[1]),
        .cout(d_cout[1])
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference per variant (index 0 Mealy, 1 Moore)
    int       m_cnt  [2];
    bit       m_busy [2];
    bit       m_done [2];
    bit       m_c    [2];
    int       m_a    [2];
    int       m_b    [2];
    int       m_sum  [2];
    int       run_len[2];

    always @(posedge clk) begin
        for (int v = 0; v < 2; v++) begin
            if (!rst_n || clr) begin
                m_cnt[v] = 0; m_busy[v] = 0; m_done[v] = 0; m_c[v] = 0;
                m_a[v] = 0; m_b[v] = 0; m_sum[v] = 0;
            end else begin
                m_done[v] = 0;
                if (m_busy[v]) begin
                    if (m_cnt[v] == W + v - 1) begin
                        int total;
                        total = m_a[v] + m_b[v] + int'(m_c[v]);
                        m_busy[v] = 0;
                        m_done[v] = 1;
                        m_sum[v] = total % (1 << W);
                        m_c[v] = (total >> W) & 1;
                        m_a[v] = 0; m_b[v] = 0;
                    end else begin
                        m_cnt[v]++;
                    end
                end else if (load) begin
                    m_a[v] = int'(opa); m_b[v] = int'(opb); m_c[v] = 0;
                end else if (start) begin
                    m_busy[v] = 1; m_cnt[v] = 0;
                end
            end
        end
    end

    // Compare every cycle, shortly after the edge
    always @(posedge clk) begin
        #2;
        cycles++;
        for (int v = 0; v < 2; v++) begin
            string rb;
            rb = (v == 1) ? "R9" : "R3";
            chk(d_busy[v] == m_busy[v], rb, "busy", int'(d_busy[v]), int'(m_busy[v]));
            chk(d_done[v] == m_done[v], "R4", "done", int'(d_done[v]), int'(m_done[v]));
            if (!m_busy[v]) begin
                chk(int'(d_sum[v]) == m_sum[v], "R5", "sum", int'(d_sum[v]), m_sum[v]);
                chk(d_cout[v] == m_c[v], "R5", "cout", int'(d_cout[v]), int'(m_c[v]));
            end
            if (!rst_n || clr) begin
                run_len[v] = 0;
            end else begin
                if (d_busy[v]) run_len[v]++;
                if (d_done[v]) begin
                    chk(run_len[v] == W + v, rb, "busy length", run_len[v], W + v);
                    run_len[v] = 0;
                end
            end
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
        opa = a; opb = b; load = 1'b1;
        step(1);
        load = 1'b0;
    endtask

    task automatic do_start();
        start = 1'b1;
        step(1);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40; i++) begin
            if (!d_busy[0] && !d_busy[1]) break;
            step(1);
        end
        step(2);
    endtask

    initial begin
        logic [W-1:0] keep;
        step(3);
        // R1: reset state
        chk(d_busy == 2'b00 && d_done == 2'b00, "R1", "reset flags", int'(d_busy), 0);
        chk(d_sum[0] == '0 && d_cout == 2'b00, "R1", "reset sum", int'(d_sum[0]), 0);
        rst_n = 1'b1;
        step(1);

        // R5: carry into the top bit
        do_load(8'hFF, 8'h01);
        do_start();
        wait_idle();
        chk(d_sum[0] == 8'h00 && d_cout[0] == 1'b1, "R5", "ff+01", int'({d_cout[0], d_sum[0]}), 'h100);
        chk(d_sum[1] == 8'h00 && d_cout[1] == 1'b1, "R9", "ff+01 moore", int'({d_cout[1], d_sum[1]}), 'h100);

        // R8: restart without load adds only the leftover carry
        do_start();
        wait_idle();
        chk(d_sum[0] == 8'h01 && d_cout[0] == 1'b0, "R8", "restart", int'({d_cout[0], d_sum[0]}), 'h001);

        // R2: load leaves sum unchanged
        keep = d_sum[0];
        do_load(8'h5A, 8'hA5);
        step(1);
        chk(d_sum[0] == keep, "R2", "sum after load", int'(d_sum[0]), int'(keep));

        // R6: load and start while busy are ignored
        do_start();
        step(2);
        do_load(8'h11, 8'h22);
        do_start();
        wait_idle();
        chk(d_sum[0] == 8'hFF && d_cout[0] == 1'b0, "R6", "busy ignore", int'({d_cout[0], d_sum[0]}), 'h0FF);

        // R7: load beats start in the same idle cycle
        opa = 8'hC8; opb = 8'hC8; load = 1'b1; start = 1'b1;
        step(1);
        load = 1'b0; start = 1'b0;
        step(1);
        chk(d_busy == 2'b00, "R7", "no start", int'(d_busy), 0);
        do_start();
        wait_idle();
        chk(d_sum[0] == 8'h90 && d_cout[0] == 1'b1, "R7", "200+200", int'({d_cout[0], d_sum[0]}), 'h190);

        // R1: clear aborts a running addition
        do_load(8'h33, 8'h44);
        do_start();
        step(3);
        clr = 1'b1;
        step(1);
        clr = 1'b0;
        step(1);
        chk(d_busy == 2'b00 && d_sum[0] == '0, "R1", "clear abort", int'(d_busy), 0);

        // Mixed patterns
        for (int i = 0; i < 30; i++) begin
            do_load(W'($urandom), W'($urandom));
            do_start();
            if (i % 5 == 0) begin
                step(1);
                do_start();
            end
            wait_idle();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule